// File: doc/BRIEF.md
# USB OUT Endpoint Receive Controller

This block is the device-side engine for OUT transactions on a single USB endpoint. An upstream packet receiver has already decoded the token, checked CRC and bit stuffing, and split the data packet into a PID strobe, a stream of byte strobes and an end-of-packet strobe. The controller places the payload into the endpoint buffer and chooses the handshake to return. It also keeps the endpoint's toggle, NAK, byte-count and interrupt state.

Firmware arms the endpoint in three steps. It loads the expected data toggle, sets the buffer base and size, and clears NAK. When a good packet is accepted, the block records the byte count, flips the toggle, sets NAK again and raises the interrupt. Firmware then reads the count, fetches the bytes through a registered read port, clears the interrupt and clears NAK to take the next packet. Damaged or oversized packets get no reply, so the host retries them.

Top module: `usbo_ep_rx`

## Requirements
- R1: After synchronous reset, ep_toggle=0, ep_nak=1, ep_count=0, ep_irq=0 and hs_vld=0.
- R2: While cfg_en=0 the endpoint ignores tokens and data, returns no handshake and changes no state.
- R3: An error-free packet received with NAK=0, STALL=0 and a data PID matching the toggle (rx_pid_odd=1 means DATA1) returns ACK (hs_code=1). In the same cycle ep_count takes the byte count, ep_toggle inverts, ep_nak goes to 1 and ep_irq goes to 1 when cfg_ie=1. Byte i is stored at buffer address cfg_base+i.
- R4: If NAK=1 when the data packet ends, the block returns NAK (hs_code=2) and leaves buffer, count and toggle unchanged.
- R5: If cfg_stall=1 when the data packet ends, the block returns STALL (hs_code=3), taking priority over NAK.
- R6: A packet flagged with a CRC error or a bit-stuff error gets no handshake and leaves toggle, NAK, count and interrupt unchanged, even when STALL is set.
- R7: A clean packet whose data PID differs from ep_toggle is answered with ACK but discarded: buffer, count, toggle, NAK and interrupt stay unchanged.
- R8: A packet of exactly cfg_size bytes is accepted. For a longer packet the extra bytes are not written, and the packet is treated as an error with no handshake.
- R9: A pulse on fw_irq_clr clears ep_irq, a pulse on fw_nak_clr clears ep_nak, and a pulse on fw_tog_ld loads fw_tog_val into ep_toggle. With cfg_ie=0 an accepted packet does not raise ep_irq.
- R10: hs_vld is a single-cycle pulse in the cycle after the end-of-packet strobe, with hs_code valid alongside it.
- R11: Buffer write addresses wrap modulo 2^BUF_AW. fw_rd_data returns the byte at fw_rd_addr one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Endpoint enable |
| cfg_ie | input | 1 | Interrupt enable |
| cfg_stall | input | 1 | Stall control |
| cfg_base | input | BUF_AW | Buffer base address |
| cfg_size | input | CNT_W | Buffer size in bytes |
| fw_tog_ld | input | 1 | Load toggle from fw_tog_val |
| fw_tog_val | input | 1 | Toggle value to load |
| fw_nak_clr | input | 1 | Clear NAK pulse |
| fw_irq_clr | input | 1 | Clear interrupt pulse |
| fw_rd_addr | input | BUF_AW | Buffer read address |
| fw_rd_data | output | 8 | Buffer read data, one cycle latency |
| rx_tok_out | input | 1 | OUT token for this endpoint seen |
| rx_pid_vld | input | 1 | Data PID strobe |
| rx_pid_odd | input | 1 | Data PID is DATA1 |
| rx_byte_vld | input | 1 | Payload byte strobe |
| rx_byte | input | 8 | Payload byte |
| rx_eop | input | 1 | End of data packet |
| rx_crc_err | input | 1 | CRC error, valid with rx_eop |
| rx_stuff_err | input | 1 | Bit-stuff error, valid with rx_eop |
| hs_vld | output | 1 | Handshake request pulse |
| hs_code | output | 2 | 1 ACK, 2 NAK, 3 STALL |
| ep_toggle | output | 1 | Expected data toggle |
| ep_nak | output | 1 | NAK state |
| ep_count | output | CNT_W | Byte count of last accepted packet |
| ep_irq | output | 1 | Endpoint interrupt |

## Verification
The bench builds the block with BUF_AW=4 and MAX_PKT=8, which gives a 16-byte buffer and a 4-bit count. It places the buffer base at 13 with a size of 6. A six-byte packet then runs across the top of the address space, so the wrap is exercised. A seven-byte packet trips the overflow path, and a short buffer setting shows that the excess bytes never reach memory. These small values also keep the full decision table (error, stall, NAK, PID mismatch, accept) to a few cycles per case.

// File: rtl/usbo_pkg.sv
package usbo_pkg;
  typedef enum logic [1:0] {
    HS_NONE  = 2'd0,
    HS_ACK   = 2'd1,
    HS_NAK   = 2'd2,
    HS_STALL = 2'd3
  } hs_e;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_WAIT_PID = 2'd1,
    ST_RECV     = 2'd2
  } rx_st_e;
endpackage

// File: rtl/usbo_dpram.sv
module usbo_dpram #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/usbo_rx_fsm.sv
module usbo_rx_fsm
  import usbo_pkg::*;
#(
  parameter int BUF_AW = 7,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_en,
  input  logic              cfg_stall,
  input  logic [BUF_AW-1:0] cfg_base,
  input  logic [CNT_W-1:0]  cfg_size,
  input  logic              ep_nak,
  input  logic              ep_toggle,
  input  logic              rx_tok_out,
  input  logic              rx_pid_vld,
  input  logic              rx_pid_odd,
  input  logic              rx_byte_vld,
  input  logic [7:0]        rx_byte,
  input  logic              rx_eop,
  input  logic              rx_crc_err,
  input  logic              rx_stuff_err,
  output logic              wr_en,
  output logic [BUF_AW-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              commit,
  output logic [CNT_W-1:0]  commit_cnt,
  output logic              hs_vld,
  output logic [1:0]        hs_code
);
  rx_st_e           st;
  logic [CNT_W-1:0] idx;
  logic             ovf;
  logic             pid_odd;

  logic at_end, pid_ok, full, take, bad;
  hs_e  hs_nx;

  always_comb begin
    at_end     = (st == ST_RECV) && rx_eop && cfg_en;
    pid_ok     = (pid_odd == ep_toggle);
    full       = (idx == cfg_size);
    take       = (st == ST_RECV) && cfg_en && rx_byte_vld && !rx_eop && !full &&
                 !ep_nak && !cfg_stall && pid_ok;
    bad        = rx_crc_err || rx_stuff_err || ovf;
    hs_nx      = HS_NONE;
    commit     = 1'b0;
    commit_cnt = idx;
    if (at_end && !bad) begin
      if (cfg_stall)   hs_nx = HS_STALL;
      else if (ep_nak) hs_nx = HS_NAK;
      else begin
        hs_nx  = HS_ACK;
        commit = pid_ok;
      end
    end
  end

  // packet sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      idx     <= '0;
      ovf     <= 1'b0;
      pid_odd <= 1'b0;
    end else if (!cfg_en) begin
      st <= ST_IDLE;
    end else if (rx_tok_out) begin
      st  <= ST_WAIT_PID;
      idx <= '0;
      ovf <= 1'b0;
    end else begin
      case (st)
        ST_WAIT_PID: begin
          if (rx_pid_vld) begin
            pid_odd <= rx_pid_odd;
            st      <= ST_RECV;
          end
        end
        ST_RECV: begin
          if (rx_eop) st <= ST_IDLE;
          else if (rx_byte_vld) begin
            if (full) ovf <= 1'b1;
            else      idx <= CNT_W'(idx + 1'b1);
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // registered buffer write port
  always_ff @(posedge clk) begin
    if (rst) wr_en <= 1'b0;
    else     wr_en <= take;
    wr_addr <= cfg_base + BUF_AW'(idx);
    wr_data <= rx_byte;
  end

  // registered handshake
  always_ff @(posedge clk) begin
    if (rst) begin
      hs_vld  <= 1'b0;
      hs_code <= HS_NONE;
    end else begin
      hs_vld  <= (hs_nx != HS_NONE);
      hs_code <= hs_nx;
    end
  end
endmodule

// File: rtl/usbo_ep_regs.sv
module usbo_ep_regs #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_ie,
  input  logic             commit,
  input  logic [CNT_W-1:0] commit_cnt,
  input  logic             fw_tog_ld,
  input  logic             fw_tog_val,
  input  logic             fw_nak_clr,
  input  logic             fw_irq_clr,
  output logic             ep_toggle,
  output logic             ep_nak,
  output logic [CNT_W-1:0] ep_count,
  output logic             ep_irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ep_toggle <= 1'b0;
      ep_nak    <= 1'b1;
      ep_count  <= '0;
      ep_irq    <= 1'b0;
    end else if (commit) begin
      ep_toggle <= ~ep_toggle;
      ep_nak    <= 1'b1;
      ep_count  <= commit_cnt;
      if (cfg_ie) ep_irq <= 1'b1;
      else if (fw_irq_clr) ep_irq <= 1'b0;
    end else begin
      if (fw_tog_ld)  ep_toggle <= fw_tog_val;
      if (fw_nak_clr) ep_nak    <= 1'b0;
      if (fw_irq_clr) ep_irq    <= 1'b0;
    end
  end
endmodule

// File: rtl/usbo_ep_rx.sv
module usbo_ep_rx #(
  parameter int BUF_AW  = 7,
  parameter int MAX_PKT = 64,
  parameter int CNT_W   = $clog2(MAX_PKT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_en,
  input  logic              cfg_ie,
  input  logic              cfg_stall,
  input  logic [BUF_AW-1:0] cfg_base,
  input  logic [CNT_W-1:0]  cfg_size,
  input  logic              fw_tog_ld,
  input  logic              fw_tog_val,
  input  logic              fw_nak_clr,
  input  logic              fw_irq_clr,
  input  logic [BUF_AW-1:0] fw_rd_addr,
  output logic [7:0]        fw_rd_data,
  input  logic              rx_tok_out,
  input  logic              rx_pid_vld,
  input  logic              rx_pid_odd,
  input  logic              rx_byte_vld,
  input  logic [7:0]        rx_byte,
  input  logic              rx_eop,
  input  logic              rx_crc_err,
  input  logic              rx_stuff_err,
  output logic              hs_vld,
  output logic [1:0]        hs_code,
  output logic              ep_toggle,
  output logic              ep_nak,
  output logic [CNT_W-1:0]  ep_count,
  output logic              ep_irq
);
  logic              wr_en;
  logic [BUF_AW-1:0] wr_addr;
  logic [7:0]        wr_data;
  logic              commit;
  logic [CNT_W-1:0]  commit_cnt;

  usbo_rx_fsm #(.BUF_AW(BUF_AW), .CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_stall(cfg_stall),
    .cfg_base(cfg_base), .cfg_size(cfg_size),
    .ep_nak(ep_nak), .ep_toggle(ep_toggle),
    .rx_tok_out(rx_tok_out), .rx_pid_vld(rx_pid_vld), .rx_pid_odd(rx_pid_odd),
    .rx_byte_vld(rx_byte_vld), .rx_byte(rx_byte), .rx_eop(rx_eop),
    .rx_crc_err(rx_crc_err), .rx_stuff_err(rx_stuff_err),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .commit(commit), .commit_cnt(commit_cnt),
    .hs_vld(hs_vld), .hs_code(hs_code)
  );

  usbo_ep_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .cfg_ie(cfg_ie),
    .commit(commit), .commit_cnt(commit_cnt),
    .fw_tog_ld(fw_tog_ld), .fw_tog_val(fw_tog_val),
    .fw_nak_clr(fw_nak_clr), .fw_irq_clr(fw_irq_clr),
    .ep_toggle(ep_toggle), .ep_nak(ep_nak), .ep_count(ep_count), .ep_irq(ep_irq)
  );

  usbo_dpram #(.AW(BUF_AW), .DW(8)) u_buf (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .raddr(fw_rd_addr), .rdata(fw_rd_data)
  );
endmodule

// File: rtl/usbo_ep_rx_chk.sv
module usbo_ep_rx_chk #(
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_en,
  input logic             cfg_ie,
  input logic             cfg_stall,
  input logic             fw_tog_ld,
  input logic             rx_eop,
  input logic             hs_vld,
  input logic [1:0]       hs_code,
  input logic             ep_toggle,
  input logic             ep_nak,
  input logic [CNT_W-1:0] ep_count,
  input logic             ep_irq
);
  p_hs_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    hs_vld |=> !hs_vld);

  p_hs_after_eop_r10: assert property (@(posedge clk) disable iff (rst)
    hs_vld |-> $past(rx_eop));

  p_disabled_silent_r2: assert property (@(posedge clk) disable iff (rst)
    hs_vld |-> $past(cfg_en));

  p_toggle_on_ack_r3: assert property (@(posedge clk) disable iff (rst)
    ((ep_toggle != $past(ep_toggle)) && !$past(fw_tog_ld)) |-> (hs_vld && hs_code == 2'd1 && ep_nak));

  p_nak_holds_r4: assert property (@(posedge clk) disable iff (rst)
    (hs_vld && hs_code == 2'd2 && !$past(fw_tog_ld)) |-> (ep_count == $past(ep_count) && ep_toggle == $past(ep_toggle)));

  p_stall_wins_r5: assert property (@(posedge clk) disable iff (rst)
    (hs_vld && $past(cfg_stall)) |-> (hs_code == 2'd3));

  p_irq_needs_ie_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(ep_irq) |-> ($past(cfg_ie) && hs_vld));
endmodule

bind usbo_ep_rx usbo_ep_rx_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_ie(cfg_ie), .cfg_stall(cfg_stall),
  .fw_tog_ld(fw_tog_ld), .rx_eop(rx_eop), .hs_vld(hs_vld), .hs_code(hs_code),
  .ep_toggle(ep_toggle), .ep_nak(ep_nak), .ep_count(ep_count), .ep_irq(ep_irq)
);

// File: tb/tb_usbo_ep_rx.sv
module tb_usbo_ep_rx;
  localparam int BUF_AW  = 4;
  localparam int MAX_PKT = 8;
  localparam int CNT_W   = $clog2(MAX_PKT + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_en = 1'b1, cfg_ie = 1'b1, cfg_stall = 1'b0;
  logic [BUF_AW-1:0] cfg_base = 4'd13;
  logic [CNT_W-1:0]  cfg_size = 4'd6;
  logic fw_tog_ld = 0, fw_tog_val = 0, fw_nak_clr = 0, fw_irq_clr = 0;
  logic [BUF_AW-1:0] fw_rd_addr = '0;
  logic [7:0] fw_rd_data;
  logic rx_tok_out = 0, rx_pid_vld = 0, rx_pid_odd = 0, rx_byte_vld = 0;
  logic [7:0] rx_byte = '0;
  logic rx_eop = 0, rx_crc_err = 0, rx_stuff_err = 0;
  logic hs_vld;
  logic [1:0] hs_code;
  logic ep_toggle, ep_nak, ep_irq;
  logic [CNT_W-1:0] ep_count;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  usbo_ep_rx #(.BUF_AW(BUF_AW), .MAX_PKT(MAX_PKT)) dut (.*);

  typedef struct packed {
    logic [3:0] req;
    logic en, st, nak, tog, pid;
    logic [3:0] nb;
    logic crc, stf;
    logic [1:0] hs;
    logic etog, enak;
    logic [3:0] ecnt;
    logic eirq;
  } vec_t;

  // req en st nak tog pid nb crc stf hs etog enak ecnt eirq ; cfg_size=6
  localparam vec_t VT [12] = '{
    '{4'd3, 1,0,0,0,0, 4'd3, 0,0, 2'd1, 1,1, 4'd3, 1},  // R3 good DATA0
    '{4'd8, 1,0,0,1,1, 4'd6, 0,0, 2'd1, 0,1, 4'd6, 1},  // R8 exact size, DATA1
    '{4'd3, 1,0,0,0,0, 4'd0, 0,0, 2'd1, 1,1, 4'd0, 1},  // R3 zero length
    '{4'd4, 1,0,1,0,0, 4'd2, 0,0, 2'd2, 0,1, 4'd0, 0},  // R4 NAK
    '{4'd5, 1,1,0,0,0, 4'd2, 0,0, 2'd3, 0,0, 4'd0, 0},  // R5 STALL
    '{4'd5, 1,1,1,0,0, 4'd2, 0,0, 2'd3, 0,1, 4'd0, 0},  // R5 STALL over NAK
    '{4'd6, 1,0,0,0,0, 4'd3, 1,0, 2'd0, 0,0, 4'd0, 0},  // R6 CRC error
    '{4'd6, 1,0,0,1,1, 4'd3, 0,1, 2'd0, 1,0, 4'd0, 0},  // R6 bit-stuff error
    '{4'd7, 1,0,0,0,1, 4'd3, 0,0, 2'd1, 0,0, 4'd0, 0},  // R7 PID mismatch
    '{4'd8, 1,0,0,0,0, 4'd7, 0,0, 2'd0, 0,0, 4'd0, 0},  // R8 overflow
    '{4'd2, 0,0,0,0,0, 4'd3, 0,0, 2'd0, 0,0, 4'd0, 0},  // R2 disabled
    '{4'd6, 1,1,0,0,0, 4'd3, 1,0, 2'd0, 0,0, 4'd0, 0}   // R6 error beats STALL
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic tog_ld(input logic v);
    fw_tog_ld = 1'b1; fw_tog_val = v;
    @(negedge clk);
    fw_tog_ld = 1'b0;
  endtask

  task automatic nak_clr();
    fw_nak_clr = 1'b1;
    @(negedge clk);
    fw_nak_clr = 1'b0;
  endtask

  task automatic irq_clr();
    fw_irq_clr = 1'b1;
    @(negedge clk);
    fw_irq_clr = 1'b0;
  endtask

  task automatic rd(input logic [BUF_AW-1:0] a, output logic [7:0] d);
    fw_rd_addr = a;
    @(negedge clk);
    d = fw_rd_data;
  endtask

  // ends on the negedge after the end-of-packet edge
  task automatic send_pkt(input logic pid, input int nb, input logic [7:0] seed,
                          input logic crc, input logic stf);
    rx_tok_out = 1'b1;
    @(negedge clk);
    rx_tok_out = 1'b0;
    rx_pid_vld = 1'b1; rx_pid_odd = pid;
    @(negedge clk);
    rx_pid_vld = 1'b0;
    for (int i = 0; i < nb; i++) begin
      rx_byte_vld = 1'b1; rx_byte = seed + 8'(i);
      @(negedge clk);
    end
    rx_byte_vld = 1'b0;
    rx_eop = 1'b1; rx_crc_err = crc; rx_stuff_err = stf;
    @(negedge clk);
    rx_eop = 1'b0; rx_crc_err = 1'b0; rx_stuff_err = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual 0 expected 1 (run did not end)");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 hs_vld", int'(hs_vld), 0);
    chk("R1 toggle", int'(ep_toggle), 0);
    chk("R1 nak", int'(ep_nak), 1);
    chk("R1 count", int'(ep_count), 0);
    chk("R1 irq", int'(ep_irq), 0);

    foreach (VT[k]) begin
      vec_t v;
      string tag;
      v = VT[k];
      tag = $sformatf("R%0d vec%0d", v.req, k);
      do_reset();
      tog_ld(v.tog);
      if (!v.nak) nak_clr();
      cfg_stall = v.st;
      cfg_en = v.en;
      send_pkt(v.pid, int'(v.nb), 8'hA0, v.crc, v.stf);
      chk({tag, " hs_vld"}, int'(hs_vld), int'(v.hs != 2'd0));
      if (v.hs != 2'd0) chk({tag, " hs_code"}, int'(hs_code), int'(v.hs));
      chk({tag, " toggle"}, int'(ep_toggle), int'(v.etog));
      chk({tag, " nak"}, int'(ep_nak), int'(v.enak));
      chk({tag, " count"}, int'(ep_count), int'(v.ecnt));
      chk({tag, " irq"}, int'(ep_irq), int'(v.eirq));
      @(negedge clk);
      chk("R10 hs pulse width", int'(hs_vld), 0);
      cfg_en = 1'b1;
      cfg_stall = 1'b0;
    end

    // R3 / R11: good packet across the top of the buffer
    do_reset();
    nak_clr();
    send_pkt(1'b0, 6, 8'h30, 1'b0, 1'b0);
    chk("R3 ack", int'(hs_code), 1);
    chk("R3 count", int'(ep_count), 6);
    for (int i = 0; i < 6; i++) begin
      rd(4'(13 + i), d);
      chk($sformatf("R11 buf[%0d]", (13 + i) % 16), int'(d), 8'h30 + i);
    end

    // R4: NAKed packet leaves buffer and count alone
    send_pkt(1'b1, 4, 8'h70, 1'b0, 1'b0);
    chk("R4 nak code", int'(hs_code), 2);
    chk("R4 count kept", int'(ep_count), 6);
    rd(4'd13, d);
    chk("R4 buffer kept", int'(d), 8'h30);

    // R9: firmware clears
    irq_clr();
    chk("R9 irq cleared", int'(ep_irq), 0);
    nak_clr();
    chk("R9 nak cleared", int'(ep_nak), 0);

    // R7: mismatched PID (toggle is 1, send DATA0)
    send_pkt(1'b0, 4, 8'h70, 1'b0, 1'b0);
    chk("R7 ack code", int'(hs_code), 1);
    chk("R7 toggle kept", int'(ep_toggle), 1);
    chk("R7 count kept", int'(ep_count), 6);
    chk("R7 irq quiet", int'(ep_irq), 0);
    rd(4'd14, d);
    chk("R7 buffer kept", int'(d), 8'h31);

    // R9: interrupt disabled
    cfg_ie = 1'b0;
    send_pkt(1'b1, 2, 8'h50, 1'b0, 1'b0);
    chk("R9 ack no-ie", int'(hs_code), 1);
    chk("R9 count no-ie", int'(ep_count), 2);
    chk("R9 irq off", int'(ep_irq), 0);
    cfg_ie = 1'b1;
    tog_ld(1'b1);
    chk("R9 toggle load", int'(ep_toggle), 1);

    // R8: bytes past the size never reach memory
    cfg_size = 4'd3;
    nak_clr();
    send_pkt(1'b1, 5, 8'h90, 1'b0, 1'b0);
    chk("R8 no handshake", int'(hs_vld), 0);
    chk("R8 count kept", int'(ep_count), 2);
    rd(4'd0, d);
    chk("R8 dropped byte", int'(d), 8'h33);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule